// File: doc/BRIEF.md
# In-Order Retirement Queue with Mispredict Squash

This block is a circular reorder buffer for an out-of-order core. The front end writes instructions into it in program order and gets back an entry index for each one. The execution units report finished work by that index, in any order. The block retires entries strictly from the oldest end, up to two per cycle, and only once they have finished.

A branch entry can be completed with a mispredict flag. When such a branch reaches the oldest position and retires, the block retires it, drops every younger entry, and pulls the tail pointer back to the new head. On the following cycle it raises a one-cycle flush pulse so that the front end can redirect. Each pointer carries one extra wrap bit beyond the index bits. This bit tells a full buffer apart from an empty one.

Top module: `retire_queue`

## Requirements
- R1: During and right after reset the buffer is empty: `alloc_ready` is 1, `alloc_idx` is 0, both commit slots are idle and `flush` is 0.
- R2: Each accepted allocation (`alloc_valid` and `alloc_ready` high at a rising edge) takes the index shown on `alloc_idx`. The next index is that value plus one, modulo DEPTH.
- R3: When DEPTH entries are live, `alloc_ready` is 0 and `alloc_valid` has no effect. A slot freed by a retirement can be allocated from the following cycle onward.
- R4: Completion only marks an entry as finished. Slot 0 shows the oldest live entry, with its index and payload, and only once that entry has finished. A finished entry behind an unfinished one does not retire.
- R5: Slot 1 retires the second-oldest entry in the same cycle only if slot 0 retires, the slot-0 entry is not a mispredicted branch, and the second entry has finished.
- R6: When a mispredicted branch retires, all younger entries are discarded and the buffer becomes empty. `flush` is 1 for exactly the next cycle.
- R7: A completion whose index names an entry that is not live, including an entry dropped by a squash, changes nothing. A later entry allocated at that index still waits for its own completion.
- R8: In the cycle in which a mispredicted branch retires, `alloc_ready` is 0 and no allocation is accepted.
- R9: A finished entry directly behind a retiring mispredicted branch never appears on slot 1.
- R10: The mispredict flag of a completion takes effect only for entries allocated with `alloc_br` = 1. A non-branch entry completed with the flag set retires normally and causes no flush.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_valid | input | 1 | Request to add an instruction at the tail |
| alloc_br | input | 1 | The instruction being added is a branch |
| alloc_data | input | DW | Payload stored with the entry |
| alloc_ready | output | 1 | An allocation is accepted this cycle |
| alloc_idx | output | $clog2(DEPTH) | Index given to the instruction being added |
| cmpl_valid | input | 1 | An execution result is reported |
| cmpl_idx | input | $clog2(DEPTH) | Entry the result belongs to |
| cmpl_mis | input | 1 | The reported branch was mispredicted |
| cmt0_valid | output | 1 | The oldest entry retires this cycle |
| cmt0_idx | output | $clog2(DEPTH) | Index of the slot-0 entry |
| cmt0_data | output | DW | Payload of the slot-0 entry |
| cmt1_valid | output | 1 | The second-oldest entry retires this cycle |
| cmt1_idx | output | $clog2(DEPTH) | Index of the slot-1 entry |
| cmt1_data | output | DW | Payload of the slot-1 entry |
| flush | output | 1 | One-cycle pulse after a mispredicted branch retires |

## Verification
The bench builds the queue with DEPTH = 4 and DW = 6. With four entries, a few allocations fill the buffer, so the full stall and the recovery from it come up many times. The head and tail also wrap around the ring often, which exercises the wrap bit on both the full and the empty side. A squash in a buffer this small often lands while a stale completion or a new allocation targets one of the indices it has just released. This covers the ignored-completion case and the allocation-block case many times over a run of a few thousand cycles.

// File: rtl/retq_pkg.sv
// Package: shared types for the retirement queue.
// Assumes: nothing; holds only the per-entry flag record.
package retq_pkg;

    // Per-entry status bits. The payload is kept separately because its width is a parameter.
    typedef struct packed {
        logic valid;   // entry holds a live instruction
        logic done;    // execution has finished
        logic br;      // entry is a branch
        logic mis;     // branch finished as mispredicted
    } retq_flag_t;

    // Number of entries retired in one cycle (0, 1 or 2).
    typedef logic [1:0] retq_ncmt_t;

endpackage

// File: rtl/retq_ptrs.sv
// Module: head and tail pointers of the ring, each with one wrap bit.
// Assumes: DEPTH is a power of two, at least 2. The caller never allocates
// while full or while a squash is taking place.
module retq_ptrs #(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       alloc_fire,
    input  retq_pkg::retq_ncmt_t       n_cmt,
    input  logic                       squash,
    output logic [$clog2(DEPTH)-1:0]   head_idx,
    output logic [$clog2(DEPTH)-1:0]   tail_idx,
    output logic                       full,
    output logic                       empty
);
    localparam int IW = $clog2(DEPTH);
    localparam int PW = IW + 1;

    logic [PW-1:0] head_q;
    logic [PW-1:0] tail_q;
    logic [PW-1:0] head_next;
    logic [PW-1:0] occ;

    // New head after this cycle's retirements.
    always_comb begin
        head_next = head_q + PW'(n_cmt);
    end

    // Advance the head on retirement; move the tail on allocation, or snap it to the head on a squash.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            head_q <= head_next;
            if (squash) begin
                tail_q <= head_next;
            end else if (alloc_fire) begin
                tail_q <= tail_q + PW'(1);
            end
        end
    end

    // Derive the indices and the full/empty state from the pointers.
    always_comb begin
        head_idx = head_q[IW-1:0];
        tail_idx = tail_q[IW-1:0];
        empty    = (head_q == tail_q);
        full     = (head_q[IW] != tail_q[IW]) && (head_q[IW-1:0] == tail_q[IW-1:0]);
        occ      = tail_q - head_q;
    end

    // The number of live entries never exceeds the capacity.
    p_occ_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= PW'(DEPTH));

    // An accepted allocation moves the tail forward by exactly one.
    p_alloc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_fire && !squash) |=> (tail_q == $past(tail_q) + PW'(1)));

    // After a squash the ring is empty.
    p_squash_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> (head_q == tail_q));

endmodule

// File: rtl/retq_store.sv
// Module: entry storage. Holds a flag record and a payload per entry.
// Assumes: the allocation index always names a free entry. Retiring and
// clearing take priority over completion in the same cycle.
module retq_store #(
    parameter int DEPTH = 8,
    parameter int DW    = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       alloc_fire,
    input  logic [$clog2(DEPTH)-1:0]   alloc_idx,
    input  logic                       alloc_br,
    input  logic [DW-1:0]              alloc_data,
    input  logic                       cmpl_valid,
    input  logic [$clog2(DEPTH)-1:0]   cmpl_idx,
    input  logic                       cmpl_mis,
    input  logic                       clr_all,
    input  logic [DEPTH-1:0]           ret_mask,
    output retq_pkg::retq_flag_t       flags [DEPTH],
    output logic [DW-1:0]              data  [DEPTH]
);
    localparam int IW = $clog2(DEPTH);

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic hit_alloc;
        logic hit_cmpl;

        // Decode whether this entry is targeted by an allocation or a completion.
        always_comb begin
            hit_alloc = alloc_fire && (alloc_idx == IW'(i));
            hit_cmpl  = cmpl_valid && (cmpl_idx == IW'(i))
                        && flags[i].valid && !flags[i].done;
        end

        // Update the flag record: clear, fill on allocation, or mark finished.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[i] <= '0;
            end else if (clr_all || ret_mask[i]) begin
                flags[i] <= '0;
            end else if (hit_alloc) begin
                flags[i].valid <= 1'b1;
                flags[i].done  <= 1'b0;
                flags[i].br    <= alloc_br;
                flags[i].mis   <= 1'b0;
            end else if (hit_cmpl) begin
                flags[i].done <= 1'b1;
                flags[i].mis  <= cmpl_mis && flags[i].br;
            end
        end

        // Capture the payload on allocation; it needs no reset.
        always_ff @(posedge clk) begin
            if (hit_alloc) begin
                data[i] <= alloc_data;
            end
        end

        // A free entry never carries a finished mark.
        p_idle_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !flags[i].valid |-> !flags[i].done);

        // Only branch entries can hold a mispredict mark.
        p_mis_branch_r10: assert property (@(posedge clk) disable iff (!rst_n)
            flags[i].mis |-> flags[i].br);

        // A finished live entry stays finished until it leaves the buffer.
        p_done_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i].valid && flags[i].done) |=> (flags[i].done || !flags[i].valid));
    end

endmodule

// File: rtl/retq_select.sv
// Module: choose which entries retire this cycle (two slots, oldest first).
// Assumes: head_idx names the oldest entry; entries are contiguous from there.
module retq_select #(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  retq_pkg::retq_flag_t       flags [DEPTH],
    input  logic [$clog2(DEPTH)-1:0]   head_idx,
    output logic                       c0,
    output logic                       c1,
    output logic [$clog2(DEPTH)-1:0]   idx0,
    output logic [$clog2(DEPTH)-1:0]   idx1,
    output logic                       squash,
    output retq_pkg::retq_ncmt_t       n_cmt
);
    localparam int IW = $clog2(DEPTH);

    retq_pkg::retq_flag_t f0;
    retq_pkg::retq_flag_t f1;

    // Read the two oldest entries and apply the in-order retirement rules.
    always_comb begin
        idx0   = head_idx;
        idx1   = head_idx + IW'(1);
        f0     = flags[idx0];
        f1     = flags[idx1];
        c0     = f0.valid && f0.done;
        c1     = c0 && !f0.mis && f1.valid && f1.done;
        squash = (c0 && f0.mis) || (c1 && f1.mis);
        n_cmt  = {1'b0, c0} + {1'b0, c1};
    end

    // Slot 1 never retires on its own.
    p_slot_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        c1 |-> c0);

    // Nothing passes a retiring mispredicted branch.
    p_no_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (c0 && flags[head_idx].mis) |-> !c1);

endmodule

// File: rtl/retire_queue.sv
// Module: top of the in-order retirement queue with mispredict squash.
// Assumes: DEPTH is a power of two, at least 2. A completion names the index
// that allocation returned for that instruction.
module retire_queue #(
    parameter int DEPTH = 8,
    parameter int DW    = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       alloc_valid,
    input  logic                       alloc_br,
    input  logic [DW-1:0]              alloc_data,
    output logic                       alloc_ready,
    output logic [$clog2(DEPTH)-1:0]   alloc_idx,
    input  logic                       cmpl_valid,
    input  logic [$clog2(DEPTH)-1:0]   cmpl_idx,
    input  logic                       cmpl_mis,
    output logic                       cmt0_valid,
    output logic [$clog2(DEPTH)-1:0]   cmt0_idx,
    output logic [DW-1:0]              cmt0_data,
    output logic                       cmt1_valid,
    output logic [$clog2(DEPTH)-1:0]   cmt1_idx,
    output logic [DW-1:0]              cmt1_data,
    output logic                       flush
);
    localparam int IW = $clog2(DEPTH);

    logic                  full;
    logic                  empty;
    logic                  alloc_fire;
    logic                  squash;
    logic                  c0;
    logic                  c1;
    logic [IW-1:0]         head_idx;
    logic [IW-1:0]         tail_idx;
    logic [IW-1:0]         idx0;
    logic [IW-1:0]         idx1;
    logic [DEPTH-1:0]      ret_mask;
    logic                  flush_q;
    retq_pkg::retq_ncmt_t  n_cmt;
    retq_pkg::retq_flag_t  flags [DEPTH];
    logic [DW-1:0]         data  [DEPTH];

    // Accept allocations only when there is room and no squash is under way.
    always_comb begin
        alloc_ready = !full && !squash;
        alloc_fire  = alloc_valid && alloc_ready;
        alloc_idx   = tail_idx;
    end

    // One-hot mask of the entries that leave through the commit slots.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ret_mask[i] = (c0 && (idx0 == IW'(i))) || (c1 && (idx1 == IW'(i)));
        end
    end

    // Drive the commit slots from the selected entries.
    always_comb begin
        cmt0_valid = c0;
        cmt0_idx   = idx0;
        cmt0_data  = data[idx0];
        cmt1_valid = c1;
        cmt1_idx   = idx1;
        cmt1_data  = data[idx1];
        flush      = flush_q;
    end

    // Register the squash into a one-cycle flush pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_q <= 1'b0;
        end else begin
            flush_q <= squash;
        end
    end

    retq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_fire (alloc_fire),
        .n_cmt      (n_cmt),
        .squash     (squash),
        .head_idx   (head_idx),
        .tail_idx   (tail_idx),
        .full       (full),
        .empty      (empty)
    );

    retq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_fire (alloc_fire),
        .alloc_idx  (tail_idx),
        .alloc_br   (alloc_br),
        .alloc_data (alloc_data),
        .cmpl_valid (cmpl_valid),
        .cmpl_idx   (cmpl_idx),
        .cmpl_mis   (cmpl_mis),
        .clr_all    (squash),
        .ret_mask   (ret_mask),
        .flags      (flags),
        .data       (data)
    );

    retq_select #(.DEPTH(DEPTH)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .flags    (flags),
        .head_idx (head_idx),
        .c0       (c0),
        .c1       (c1),
        .idx0     (idx0),
        .idx1     (idx1),
        .squash   (squash),
        .n_cmt    (n_cmt)
    );

    // The flush pulse lasts one cycle.
    p_flush_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);

    // While the flush pulse is high the buffer is empty and nothing retires.
    p_flush_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (empty && !cmt0_valid));

    // An empty buffer retires nothing.
    p_empty_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !cmt0_valid);

endmodule

// File: tb/sim_retire_queue.sv
module sim_retire_queue;
    localparam int DEPTH      = 4;
    localparam int DW         = 6;
    localparam int IW         = 2;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_valid = 1'b0;
    logic          alloc_br = 1'b0;
    logic [DW-1:0] alloc_data = '0;
    logic          alloc_ready;
    logic [IW-1:0] alloc_idx;
    logic          cmpl_valid = 1'b0;
    logic [IW-1:0] cmpl_idx = '0;
    logic          cmpl_mis = 1'b0;
    logic          cmt0_valid;
    logic [IW-1:0] cmt0_idx;
    logic [DW-1:0] cmt0_data;
    logic          cmt1_valid;
    logic [IW-1:0] cmt1_idx;
    logic [DW-1:0] cmt1_data;
    logic          flush;

    int checks = 0;
    int bad    = 0;
    bit finished = 0;

    typedef struct {
        int idx;
        int data;
        bit br;
        bit done;
        bit mis;
    } ent_t;

    ent_t q[$];
    int   hidx = 0;
    bit   flush_exp = 0;

    retire_queue #(.DEPTH(DEPTH), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_br(alloc_br), .alloc_data(alloc_data),
        .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx), .cmpl_mis(cmpl_mis),
        .cmt0_valid(cmt0_valid), .cmt0_idx(cmt0_idx), .cmt0_data(cmt0_data),
        .cmt1_valid(cmt1_valid), .cmt1_idx(cmt1_idx), .cmt1_data(cmt1_data),
        .flush(flush)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare just after, update the model at the rising edge.
    task automatic step(input string tag, input bit av, input bit abr, input int ad,
                        input bit cv, input int ci, input bit cm);
        int sz;
        bit c0e;
        bit c1e;
        bit fl;
        bit rdy;
        int pidx;
        alloc_valid = av;
        alloc_br    = abr;
        alloc_data  = DW'(ad);
        cmpl_valid  = cv;
        cmpl_idx    = IW'(ci);
        cmpl_mis    = cm;
        #1;
        sz   = q.size();
        c0e  = (sz >= 1) && q[0].done;
        c1e  = c0e && !q[0].mis && (sz >= 2) && q[1].done;
        fl   = (c0e && q[0].mis) || (c1e && q[1].mis);
        rdy  = (sz < DEPTH) && !fl;
        pidx = (hidx + sz) % DEPTH;
        chk({tag, fl ? " R8 alloc_ready" : " R3 alloc_ready"}, int'(alloc_ready), int'(rdy));
        chk({tag, " R2 alloc_idx"}, int'(alloc_idx), pidx);
        chk({tag, " R4 cmt0_valid"}, int'(cmt0_valid), int'(c0e));
        if (c0e) begin
            chk({tag, " R4 cmt0_idx"}, int'(cmt0_idx), q[0].idx);
            chk({tag, " R4 cmt0_data"}, int'(cmt0_data), q[0].data);
        end
        chk({tag, (sz >= 1 && q[0].mis) ? " R9 cmt1_valid" : " R5 cmt1_valid"},
            int'(cmt1_valid), int'(c1e));
        if (c1e) begin
            chk({tag, " R5 cmt1_idx"}, int'(cmt1_idx), q[1].idx);
            chk({tag, " R5 cmt1_data"}, int'(cmt1_data), q[1].data);
        end
        chk({tag, " R6 flush"}, int'(flush), int'(flush_exp));
        @(posedge clk);
        // R7: a completion only lands on a live, unfinished entry.
        if (cv) begin
            for (int k = 0; k < q.size(); k++) begin
                if (q[k].idx == ci && !q[k].done) begin
                    q[k].done = 1;
                    q[k].mis  = cm && q[k].br;  // R10: flag counts only for branches
                end
            end
        end
        if (c1e) void'(q.pop_front());
        if (c0e) void'(q.pop_front());
        hidx = (hidx + int'(c0e) + int'(c1e)) % DEPTH;
        if (fl) q.delete();
        flush_exp = fl;
        if (av && rdy) q.push_back('{idx: pidx, data: ad % (1 << DW), br: abr, done: 0, mis: 0});
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: state seen while reset is held.
        chk("R1 alloc_ready", int'(alloc_ready), 1);
        chk("R1 alloc_idx", int'(alloc_idx), 0);
        chk("R1 cmt0_valid", int'(cmt0_valid), 0);
        chk("R1 cmt1_valid", int'(cmt1_valid), 0);
        chk("R1 flush", int'(flush), 0);
        rst_n = 1'b1;

        // Fill the ring, then try one more (R3).
        step("fill", 1, 0, 11, 0, 0, 0);
        step("fill", 1, 1, 12, 0, 0, 0);
        step("fill", 1, 0, 13, 0, 0, 0);
        step("fill", 1, 0, 14, 0, 0, 0);
        step("R3 full", 1, 0, 15, 0, 0, 0);
        // Out-of-order completion: no retirement until the head finishes (R4).
        step("R4 ooo", 0, 0, 0, 1, 3, 0);
        step("R4 ooo", 0, 0, 0, 1, 2, 0);
        step("R4 head", 0, 0, 0, 1, 0, 0);
        step("R5 pair", 0, 0, 0, 1, 1, 0);
        step("R5 pair", 0, 0, 0, 0, 0, 0);
        step("drain", 0, 0, 0, 0, 0, 0);
        step("drain", 0, 0, 0, 0, 0, 0);

        // Mispredict scenario: A, B(branch), C, D; head is index 0 again.
        step("mis", 1, 0, 21, 0, 0, 0);
        step("mis", 1, 1, 22, 0, 0, 0);
        step("mis", 1, 0, 23, 0, 0, 0);
        step("mis", 1, 0, 24, 0, 0, 0);
        step("mis", 0, 0, 0, 1, 2, 0);
        step("mis", 0, 0, 0, 1, 3, 0);
        step("R10 nonbr flag", 0, 0, 0, 1, 0, 1);
        step("R6 branch done", 0, 0, 0, 1, 1, 1);
        step("R8 R9 squash", 1, 0, 30, 0, 0, 0);
        step("R7 stale", 1, 0, 31, 1, 2, 0);
        step("R7 stale", 0, 0, 0, 0, 0, 0);
        step("R7 wait", 0, 0, 0, 1, 2, 0);
        step("drain", 0, 0, 0, 0, 0, 0);

        // Mixed traffic.
        for (int n = 0; n < 3000; n++) begin
            bit av;
            bit abr;
            int ad;
            bit cv;
            int ci;
            bit cm;
            av  = ($urandom % 3) != 0;
            abr = ($urandom % 4) == 0;
            ad  = int'($urandom % 64);
            cv  = ($urandom % 2) == 0;
            if (q.size() > 0 && ($urandom % 4) != 0) ci = q[$urandom % q.size()].idx;
            else ci = int'($urandom % DEPTH);
            cm  = ($urandom % 5) == 0;
            step("mix", av, abr, ad, cv, ci, cm);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule